// File: doc/BRIEF.md
# Conversion Result Slot Interrupt Vector Unit

This block holds the result slots of a converter and works out which interrupt to raise. Each conversion result goes into one of sixteen slots. Writing a slot sets a pending flag for it, and software clears that flag by reading the slot. Software can also clear any set of flags through a mask.

Two error conditions are tracked. The first is an overwrite: a result lands in a slot whose previous value nobody has read. The second is a conversion-time overflow: a new conversion is requested while the converter is still busy. All eighteen sources are reduced to one request line and one even-valued vector that names the most urgent enabled source. Touching the vector acknowledges an error source, but only when that source is the one the vector is naming.

A small command-list sequencer comes with the unit. It starts at a programmed slot, moves forward one slot per completed conversion, wraps past the last slot to slot 0, and halts at the first slot whose end-of-list bit is set.

Top module: `cmem_irq_vec`

## Requirements
- R1: After reset all slot flags, both error flags, `irq`, `vec` and `seq_active` are 0 and `seq_ptr` is 0.
- R2: A write strobe (`res_wr`) to slot k sets `slot_flags[k]` on the next cycle. The written data is then returned on `res_rd_data` whenever `res_rd_idx` equals k.
- R3: A read strobe (`res_rd`) on slot k clears `slot_flags[k]` on the next cycle. Setting `flag_clr[k]` also clears it. A write to the same slot in the same cycle wins over both.
- R4: `ovw_flag` is set when a result is written to a slot that has been written and not read since. Clearing the slot's flag through `flag_clr` does not count as a read.
- R5: `tov_flag` is set when `conv_req` is high while `conv_busy` is high. A request while the converter is idle sets nothing.
- R6: `vec` reports the highest-priority enabled pending source. The codes are: 2 for overwrite (with `ovw_ie`), 4 for time overflow (with `tov_ie`), 6+2k for slot k (with `slot_ie[k]`), and 0 when nothing is pending. Overwrite ranks above time overflow, and lower slots rank above higher slots.
- R7: A `vec_acc` strobe clears `ovw_flag` only when `vec` is 2, and clears `tov_flag` only when `vec` is 4. It never changes the slot flags.
- R8: `irq` is high exactly when at least one enabled source is pending, which is exactly when `vec` is nonzero. It stays high while any such source remains after another has been serviced.
- R9: `seq_go` loads `seq_ptr` from `seq_start_ptr` and sets `seq_active`. Each `seq_step` while active does one of two things. If `seq_eos` is set for the current slot, it clears `seq_active`. Otherwise it advances `seq_ptr` by one, going from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_wr | input | 1 | Result write strobe |
| res_wr_idx | input | 4 | Slot receiving the result |
| res_wr_data | input | 12 | Result value |
| res_rd | input | 1 | Software read strobe |
| res_rd_idx | input | 4 | Slot being read |
| res_rd_data | output | 12 | Content of slot `res_rd_idx` |
| flag_clr | input | 16 | Per-slot direct flag clear |
| slot_ie | input | 16 | Per-slot interrupt enable |
| ovw_ie | input | 1 | Overwrite interrupt enable |
| tov_ie | input | 1 | Time-overflow interrupt enable |
| conv_req | input | 1 | Sample-and-convert request |
| conv_busy | input | 1 | Converter is mid-conversion |
| vec_acc | input | 1 | Vector register accessed |
| seq_go | input | 1 | Start the command list |
| seq_start_ptr | input | 4 | First slot of the list |
| seq_eos | input | 16 | Per-slot end-of-list bits |
| seq_step | input | 1 | One conversion completed |
| slot_flags | output | 16 | Per-slot pending flags |
| ovw_flag | output | 1 | Overwrite pending |
| tov_flag | output | 1 | Time overflow pending |
| irq | output | 1 | Interrupt request |
| vec | output | 6 | Encoded highest-priority source |
| seq_ptr | output | 4 | Current command-list slot |
| seq_active | output | 1 | Sequencer running |

## Verification
A wrong unread bit stays hidden until the next write to that slot. Then it either raises an overwrite that should not occur, or misses one that should, and `vec` shows the difference one cycle after the write. A wrong priority or a wrong acknowledge rule shows up as soon as two sources are pending together, so the bench sweeps every single-slot enable and every pairing of the error sources. A sequencer off by one at the wrap point moves `seq_ptr` on the step after slot 15.

// File: rtl/cmem_irq_pkg.sv
package cmem_irq_pkg;
   localparam int VEC_NONE      = 0;
   localparam int VEC_OVW       = 2;
   localparam int VEC_TOV       = 4;
   localparam int VEC_SLOT_BASE = 6;

   function automatic int vec_width(input int n_slots);
      return $clog2(VEC_SLOT_BASE + 2 * n_slots);
   endfunction
endpackage

// File: rtl/slot_flag_bank.sv
module slot_flag_bank #(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 12,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [NUM_SLOTS-1:0] clr_mask,
   input  logic                 clr_ovw,
   output logic [NUM_SLOTS-1:0] flags,
   output logic                 ovw
);
   logic [DATA_W-1:0]    mem_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] flag_q;
   logic [NUM_SLOTS-1:0] unread_q;
   logic                 ovw_q;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic hit_wr, hit_rd;
      assign hit_wr = wr && (wr_idx == IDX_W'(g));
      assign hit_rd = rd && (rd_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[g]   <= 1'b0;
            unread_q[g] <= 1'b0;
            mem_q[g]    <= '0;
         end else if (hit_wr) begin
            flag_q[g]   <= 1'b1;
            unread_q[g] <= 1'b1;
            mem_q[g]    <= wr_data;
         end else begin
            if (hit_rd)
               unread_q[g] <= 1'b0;
            if (hit_rd || clr_mask[g])
               flag_q[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovw_q <= 1'b0;
      else if (wr && unread_q[wr_idx])
         ovw_q <= 1'b1;
      else if (clr_ovw)
         ovw_q <= 1'b0;
   end

   assign rd_data = mem_q[rd_idx];
   assign flags   = flag_q;
   assign ovw     = ovw_q;

   // R2
   a_r2_wr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> flag_q[$past(wr_idx)]);
   // R3
   a_r3_rd_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !(wr && wr_idx == rd_idx)) |=> !flag_q[$past(rd_idx)]);
   // R4
   a_r4_overwrite_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && unread_q[wr_idx]) |=> ovw_q);
endmodule

// File: rtl/prio_vec_enc.sv
module prio_vec_enc
   import cmem_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int VEC_W    = vec_width(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] slot_pend,
   input  logic                 ovw_pend,
   input  logic                 tov_pend,
   output logic [VEC_W-1:0]     vec
);
   always_comb begin
      vec = VEC_W'(VEC_NONE);
      for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
         if (slot_pend[k])
            vec = VEC_W'(VEC_SLOT_BASE + 2 * k);
      end
      if (tov_pend)
         vec = VEC_W'(VEC_TOV);
      if (ovw_pend)
         vec = VEC_W'(VEC_OVW);
   end
endmodule

// File: rtl/seq_ptr_unit.sv
module seq_ptr_unit #(
   parameter int NUM_SLOTS = 16,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  logic [IDX_W-1:0]     start_ptr,
   input  logic [NUM_SLOTS-1:0] eos,
   input  logic                 step,
   output logic [IDX_W-1:0]     ptr,
   output logic                 active
);
   logic [IDX_W-1:0] ptr_q;
   logic             act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         act_q <= 1'b0;
      end else if (go) begin
         ptr_q <= start_ptr;
         act_q <= 1'b1;
      end else if (act_q && step) begin
         if (eos[ptr_q])
            act_q <= 1'b0;
         else
            ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr    = ptr_q;
   assign active = act_q;

   // R9
   a_r9_advance_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && step && !go && !eos[ptr_q]) |=> (ptr_q == $past(ptr_q) + 1'b1) && act_q);
   a_r9_stops_at_eos: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && step && !go && eos[ptr_q]) |=> !act_q);
endmodule

// File: rtl/cmem_irq_vec.sv
module cmem_irq_vec
   import cmem_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int DATA_W    = 12,
   localparam int IDX_W    = $clog2(NUM_SLOTS),
   localparam int VEC_W    = vec_width(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 res_wr,
   input  logic [IDX_W-1:0]     res_wr_idx,
   input  logic [DATA_W-1:0]    res_wr_data,
   input  logic                 res_rd,
   input  logic [IDX_W-1:0]     res_rd_idx,
   output logic [DATA_W-1:0]    res_rd_data,
   input  logic [NUM_SLOTS-1:0] flag_clr,
   input  logic [NUM_SLOTS-1:0] slot_ie,
   input  logic                 ovw_ie,
   input  logic                 tov_ie,
   input  logic                 conv_req,
   input  logic                 conv_busy,
   input  logic                 vec_acc,
   input  logic                 seq_go,
   input  logic [IDX_W-1:0]     seq_start_ptr,
   input  logic [NUM_SLOTS-1:0] seq_eos,
   input  logic                 seq_step,
   output logic [NUM_SLOTS-1:0] slot_flags,
   output logic                 ovw_flag,
   output logic                 tov_flag,
   output logic                 irq,
   output logic [VEC_W-1:0]     vec,
   output logic [IDX_W-1:0]     seq_ptr,
   output logic                 seq_active
);
   if (NUM_SLOTS < 2 || (1 << IDX_W) != NUM_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic tov_q;
   logic ack_ovw, ack_tov;

   assign ack_ovw = vec_acc && (vec == VEC_W'(VEC_OVW));
   assign ack_tov = vec_acc && (vec == VEC_W'(VEC_TOV));

   slot_flag_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (res_wr),
      .wr_idx   (res_wr_idx),
      .wr_data  (res_wr_data),
      .rd       (res_rd),
      .rd_idx   (res_rd_idx),
      .rd_data  (res_rd_data),
      .clr_mask (flag_clr),
      .clr_ovw  (ack_ovw),
      .flags    (slot_flags),
      .ovw      (ovw_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tov_q <= 1'b0;
      else if (conv_req && conv_busy)
         tov_q <= 1'b1;
      else if (ack_tov)
         tov_q <= 1'b0;
   end
   assign tov_flag = tov_q;

   prio_vec_enc #(.NUM_SLOTS(NUM_SLOTS)) enc_i (
      .slot_pend (slot_flags & slot_ie),
      .ovw_pend  (ovw_flag && ovw_ie),
      .tov_pend  (tov_q && tov_ie),
      .vec       (vec)
   );

   assign irq = (|(slot_flags & slot_ie)) || (ovw_flag && ovw_ie) || (tov_q && tov_ie);

   seq_ptr_unit #(.NUM_SLOTS(NUM_SLOTS)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (seq_go),
      .start_ptr (seq_start_ptr),
      .eos       (seq_eos),
      .step      (seq_step),
      .ptr       (seq_ptr),
      .active    (seq_active)
   );

   // R5
   a_r5_tov_on_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && conv_busy) |=> tov_flag);
   // R7
   a_r7_acc_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_acc && !res_wr && !res_rd && flag_clr == '0) |=> slot_flags == $past(slot_flags));
   a_r7_acc_ovw_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_acc && vec == VEC_W'(VEC_OVW) && !res_wr) |=> !ovw_flag);
   // R8
   a_r8_irq_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (vec != '0));
endmodule

// File: tb/cmem_irq_vec_tb_top.sv
module cmem_irq_vec_tb_top;
   localparam int CLK_P = 10;
   localparam int N     = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_wr = 0, res_rd = 0;
   logic [3:0]  res_wr_idx = 0, res_rd_idx = 0;
   logic [11:0] res_wr_data = 0;
   logic [11:0] res_rd_data;
   logic [15:0] flag_clr = 0, slot_ie = 0, seq_eos = 0;
   logic        ovw_ie = 0, tov_ie = 0, conv_req = 0, conv_busy = 0, vec_acc = 0;
   logic        seq_go = 0, seq_step = 0;
   logic [3:0]  seq_start_ptr = 0;
   logic [15:0] slot_flags;
   logic        ovw_flag, tov_flag, irq, seq_active;
   logic [5:0]  vec;
   logic [3:0]  seq_ptr;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [15:0] e_flag = 0, e_unread = 0;
   logic        e_ovw = 0, e_tov = 0;
   logic [11:0] e_mem [N];
   int          lcg = 12345;

   always #(CLK_P / 2) clk = ~clk;

   cmem_irq_vec dut_i (
      .clk(clk), .rst_n(rst_n),
      .res_wr(res_wr), .res_wr_idx(res_wr_idx), .res_wr_data(res_wr_data),
      .res_rd(res_rd), .res_rd_idx(res_rd_idx), .res_rd_data(res_rd_data),
      .flag_clr(flag_clr), .slot_ie(slot_ie), .ovw_ie(ovw_ie), .tov_ie(tov_ie),
      .conv_req(conv_req), .conv_busy(conv_busy), .vec_acc(vec_acc),
      .seq_go(seq_go), .seq_start_ptr(seq_start_ptr), .seq_eos(seq_eos), .seq_step(seq_step),
      .slot_flags(slot_flags), .ovw_flag(ovw_flag), .tov_flag(tov_flag), .irq(irq),
      .vec(vec), .seq_ptr(seq_ptr), .seq_active(seq_active)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_vec();
      if (e_ovw && ovw_ie) return 2;
      if (e_tov && tov_ie) return 4;
      for (int k = 0; k < N; k++)
         if (e_flag[k] && slot_ie[k]) return 6 + 2 * k;
      return 0;
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(input string tag);
      chk({tag, " flags"}, int'(slot_flags), int'(e_flag));
      chk({tag, " ovw"}, int'(ovw_flag), int'(e_ovw));
      chk({tag, " tov"}, int'(tov_flag), int'(e_tov));
      chk({tag, " R6 vec"}, int'(vec), exp_vec());
      chk({tag, " R8 irq"}, int'(irq), int'(exp_vec() != 0));
   endtask

   task automatic do_write(input int idx, input int data);
      res_wr = 1; res_wr_idx = 4'(idx); res_wr_data = 12'(data);
      tick();
      res_wr = 0;
      if (e_unread[idx]) e_ovw = 1;
      e_flag[idx] = 1; e_unread[idx] = 1; e_mem[idx] = 12'(data);
   endtask

   task automatic do_read(input int idx);
      res_rd = 1; res_rd_idx = 4'(idx);
      #1;
      chk("R2 read data", int'(res_rd_data), int'(e_mem[idx]));
      tick();
      res_rd = 0;
      e_flag[idx] = 0; e_unread[idx] = 0;
   endtask

   task automatic do_clr(input logic [15:0] m);
      flag_clr = m;
      tick();
      flag_clr = 0;
      e_flag = e_flag & ~m;
   endtask

   task automatic do_conv(input logic busy);
      conv_req = 1; conv_busy = busy;
      tick();
      conv_req = 0; conv_busy = 0;
      if (busy) e_tov = 1;
   endtask

   task automatic do_acc();
      int v;
      v = exp_vec();
      vec_acc = 1;
      tick();
      vec_acc = 0;
      if (v == 2) e_ovw = 0;
      if (v == 4) e_tov = 0;
   endtask

   function automatic int rnd();
      lcg = lcg * 1103515245 + 12345;
      return (lcg >>> 8) & 32'h7fff;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < N; k++) e_mem[k] = 0;
      repeat (3) tick();
      // R1: reset state
      chk("R1 flags", int'(slot_flags), 0);
      chk("R1 ovw", int'(ovw_flag), 0);
      chk("R1 tov", int'(tov_flag), 0);
      chk("R1 vec", int'(vec), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 seq_active", int'(seq_active), 0);
      chk("R1 seq_ptr", int'(seq_ptr), 0);
      rst_n = 1;
      tick();
      slot_ie = 16'hffff; ovw_ie = 1; tov_ie = 1;

      // R2: fill every slot
      for (int k = 0; k < N; k++) begin
         do_write(k, k * 37 + 5);
         check_all("R2 write");
      end
      for (int k = 0; k < N; k++) begin
         res_rd_idx = 4'(k);
         #1;
         chk("R2 stored data", int'(res_rd_data), k * 37 + 5);
      end

      // R6: single-slot enable sweep
      for (int k = 0; k < N; k++) begin
         slot_ie = 16'(1 << k);
         #1;
         chk("R6 single enable vec", int'(vec), 6 + 2 * k);
         chk("R8 single enable irq", int'(irq), 1);
      end
      slot_ie = 0;
      #1;
      chk("R8 all masked irq", int'(irq), 0);
      chk("R6 all masked vec", int'(vec), 0);
      slot_ie = 16'hffff;

      // R3 / R8: read in order, irq holds while sources remain
      for (int k = 0; k < N; k++) begin
         do_read(k);
         check_all("R3 read clears");
      end

      // R3 direct clear, R4 overwrite after clear
      do_write(3, 100);
      do_clr(16'h0008);
      check_all("R3 direct clear");
      do_write(3, 101);
      check_all("R4 overwrite after clear");

      // R5: idle request, busy request
      do_conv(0);
      check_all("R5 idle request");
      do_conv(1);
      check_all("R5 busy request");

      // R7: acknowledge order
      do_acc();
      check_all("R7 ack overwrite");
      do_acc();
      check_all("R7 ack tov");
      do_acc();
      check_all("R7 ack with slot top");

      // R7: masked overwrite is not acknowledged
      do_write(3, 102);
      do_conv(1);
      ovw_ie = 0;
      #1;
      check_all("R6 masked ovw");
      do_acc();
      check_all("R7 masked ovw kept");
      ovw_ie = 1;
      #1;
      check_all("R6 ovw unmasked");
      do_acc();
      check_all("R7 ack after unmask");
      do_read(3);
      check_all("R3 read final");

      // Mixed sweep
      for (int i = 0; i < 400; i++) begin
         int op;
         op = rnd() % 6;
         slot_ie = 16'(rnd()) | 16'(rnd() << 15);
         ovw_ie = rnd() % 4 != 0;
         tov_ie = rnd() % 4 != 0;
         case (op)
            0, 1: do_write(rnd() % N, rnd() % 4096);
            2: do_read(rnd() % N);
            3: do_clr(16'(1 << (rnd() % N)));
            4: do_conv(1'(rnd() % 2));
            default: do_acc();
         endcase
         check_all("R6 R7 mixed");
      end

      // R9: every start pointer, list length four
      for (int s = 0; s < N; s++) begin
         seq_eos = 16'(1 << ((s + 3) % N));
         seq_start_ptr = 4'(s);
         seq_go = 1;
         tick();
         seq_go = 0;
         chk("R9 load ptr", int'(seq_ptr), s);
         chk("R9 active", int'(seq_active), 1);
         for (int j = 1; j <= 3; j++) begin
            seq_step = 1;
            tick();
            seq_step = 0;
            chk("R9 step ptr", int'(seq_ptr), (s + j) % N);
            chk("R9 still active", int'(seq_active), 1);
         end
         seq_step = 1;
         tick();
         seq_step = 0;
         chk("R9 stop at eos", int'(seq_active), 0);
         chk("R9 ptr held", int'(seq_ptr), (s + 3) % N);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule